// File: doc/BRIEF.md
# Video Status Flags with Read Race Resolution

This block holds the three status bits that a video processor shows to the CPU: vertical blank, sprite-zero hit and sprite overflow. It also drives an active-low NMI line from the blank flag. It runs on the master clock. It takes the two pixel-phase enables and the line and dot counters from the timing generator, plus hit and overflow events from sprite logic. From the CPU side it takes the M2 phase, a register-window select, the read/write line and the low address bits.

A status read is decoded from the read/write line and the address, and it counts only while M2 is high. The flags are captured into a read latch on the first master cycle of the M2 high phase, so the value at the start of that phase is what the CPU receives. When M2 falls at the end of the read, the blank flag is cleared.

The set point of the blank flag can fall while such a read is in flight. In that case the set is dropped, so the CPU reads 0 and no NMI is raised for that frame. A read that finishes just before the set point also returns 0, but NMI still follows. A read that starts after the set point returns 1, and NMI is held low only from the set point until that read ends.

Top module: `vidStatusFlags`

## Requirements
- R1: On a master cycle with `pclk0En` high, `lineNum` = 241 and `dotNum` = 1, the blank flag becomes 1 from the next cycle, unless a status read is active in that cycle.
- R2: `nmiN` is 0 exactly while the blank flag is 1 and `nmiEnable` is 1. With `nmiEnable` at 0, `nmiN` stays 1 whatever the flag.
- R3: A status read requires `regSel` = 1, `cpuRw` = 1 (read) and `cpuAddr` = 2. Writes, other addresses and cycles with `regSel` = 0 neither change `rdData` nor clear the blank flag.
- R4: On the first cycle of a status read with M2 high, `rdData` captures bit 7 = blank flag, bit 6 = sprite-zero hit and bit 5 = sprite overflow, with bits 4..0 at 0. It holds that value until the next status read.
- R5: The blank flag is cleared on the first cycle with M2 low after a status read. The returned value is the one captured before the clear.
- R6: If the set point falls in any cycle of a read's M2 high phase, the set is dropped: that read returns bit 7 = 0 and `nmiN` never goes low.
- R7: If a read's M2 high phase ends at or before the set point, it returns bit 7 = 0 and `nmiN` goes low after the set point. A set in the same cycle as the read's clear wins.
- R8: If a read's M2 high phase starts after the set point, it returns bit 7 = 1, and `nmiN` is low from the set point until that read's clear.
- R9: A sprite-zero-hit event on a cycle with `pclk1En` high sets the hit flag at the second following cycle with `pclk1En` high.
- R10: A sprite-overflow event on a cycle with `pclk1En` high sets the overflow flag at that edge. Reads clear neither the hit flag nor the overflow flag.
- R11: On a cycle with `pclk0En` high, `lineNum` = 261 and `dotNum` = 1, all three flags clear together.
- R12: During reset, `rdData` is 0 and `nmiN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| pclk0En | input | 1 | First pixel-phase enable |
| pclk1En | input | 1 | Second pixel-phase enable |
| lineNum | input | 9 | Current scan line |
| dotNum | input | 9 | Current dot within the line |
| m2 | input | 1 | CPU M2 phase, high while the bus transfer is valid |
| regSel | input | 1 | CPU access falls in the register window |
| cpuRw | input | 1 | CPU read (1) or write (0) |
| cpuAddr | input | 3 | Low CPU address bits selecting the register |
| spr0HitEv | input | 1 | Sprite-zero hit event, sampled on the second pixel phase |
| sprOvfEv | input | 1 | Sprite overflow event, sampled on the second pixel phase |
| nmiEnable | input | 1 | Allows the blank flag to drive NMI |
| rdData | output | 8 | Latched status byte returned to the CPU |
| nmiN | output | 1 | Active-low NMI request |

## Verification
The main stimulus moves one status read across the blank-flag set point, one master cycle per trial, from well before the set point to well after it. Each trial records the returned bit and whether NMI ever went low. This separates the three windows: a read finishing early, a read overlapping the set point (dropped set), and a read starting late. The trial one cycle before the overlap window checks that a set beats a same-cycle clear. Separate patterns issue reads to the wrong address, writes, and reads with the window deselected, to show that neither the latch nor the flag changes. Hit events are followed by reads after one and after two second-phase edges to pin down the hit delay. Repeated reads show that hit and overflow survive reads.

// File: rtl/vidStatusPkg.sv
package vidStatusPkg;
  // Strobes passed from the control module to the flag datapath.
  typedef struct packed {
    logic latchRd;   // capture flags into the read latch
    logic setVbl;    // set blank flag (race already resolved)
    logic clrVbl;    // clear blank flag at end of status read
    logic clrAll;    // pre-render clear of all flags
    logic pixAdv;    // second pixel phase: advance hit pipe
    logic setOvf;    // set overflow flag
  } ctrlStrobeT;
endpackage

// File: rtl/statusCtrl.sv
module statusCtrl
  import vidStatusPkg::*;
#(
  parameter int LINE_W      = 9,
  parameter int DOT_W       = 9,
  parameter int ADDR_W      = 3,
  parameter int VBL_LINE    = 241,
  parameter int PRE_LINE    = 261,
  parameter int SET_DOT     = 1,
  parameter int STATUS_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pclk0En,
  input  logic              pclk1En,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [DOT_W-1:0]  dotNum,
  input  logic              m2,
  input  logic              regSel,
  input  logic              cpuRw,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              sprOvfEv,
  output ctrlStrobeT        strb
);
  localparam logic [LINE_W-1:0] VblLineC = LINE_W'(VBL_LINE);
  localparam logic [LINE_W-1:0] PreLineC = LINE_W'(PRE_LINE);
  localparam logic [DOT_W-1:0]  SetDotC  = DOT_W'(SET_DOT);
  localparam logic [ADDR_W-1:0] StatAddrC = ADDR_W'(STATUS_ADDR);

  logic m2Prev;
  logic readHeld;
  logic rdDecode;
  logic readActive;
  logic setPoint;
  logic preClear;

  assign rdDecode   = regSel && cpuRw && (cpuAddr == StatAddrC);
  assign readActive = m2 && rdDecode;
  assign setPoint   = pclk0En && (lineNum == VblLineC) && (dotNum == SetDotC);
  assign preClear   = pclk0En && (lineNum == PreLineC) && (dotNum == SetDotC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      m2Prev   <= 1'b0;
      readHeld <= 1'b0;
    end else begin
      m2Prev <= m2;
      if (readActive && !m2Prev) readHeld <= 1'b1;
      else if (!m2)              readHeld <= 1'b0;
    end
  end

  always_comb begin
    strb         = '0;
    strb.latchRd = readActive && !m2Prev;
    strb.setVbl  = setPoint && !readActive;
    strb.clrVbl  = readHeld && !m2;
    strb.clrAll  = preClear;
    strb.pixAdv  = pclk1En;
    strb.setOvf  = pclk1En && sprOvfEv;
  end
endmodule

// File: rtl/statusData.sv
module statusData
  import vidStatusPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int HIT_DELAY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  input  logic              spr0HitEv,
  input  logic              nmiEnable,
  output logic [DATA_W-1:0] rdData,
  output logic              nmiN
);
  localparam int FLAG_N = 3;
  localparam int PAD_W  = DATA_W - FLAG_N;

  logic                 vblFlag;
  logic                 hitFlag;
  logic                 ovfFlag;
  logic [HIT_DELAY-1:0] hitPipe;
  logic [FLAG_N-1:0]    rdLatch;
  logic [HIT_DELAY-1:0] hitPipeNext;

  generate
    if (HIT_DELAY == 1) begin : g_pipeOne
      assign hitPipeNext = spr0HitEv;
    end else begin : g_pipeMany
      assign hitPipeNext = {hitPipe[HIT_DELAY-2:0], spr0HitEv};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vblFlag <= 1'b0;
      hitFlag <= 1'b0;
      ovfFlag <= 1'b0;
      hitPipe <= '0;
      rdLatch <= '0;
    end else begin
      if (strb.latchRd) rdLatch <= {vblFlag, hitFlag, ovfFlag};

      if (strb.clrAll)      vblFlag <= 1'b0;
      else if (strb.setVbl) vblFlag <= 1'b1;
      else if (strb.clrVbl) vblFlag <= 1'b0;

      if (strb.clrAll) begin
        hitFlag <= 1'b0;
        ovfFlag <= 1'b0;
        hitPipe <= '0;
      end else begin
        if (strb.pixAdv) begin
          hitPipe <= hitPipeNext;
          if (hitPipe[HIT_DELAY-1]) hitFlag <= 1'b1;
        end
        if (strb.setOvf) ovfFlag <= 1'b1;
      end
    end
  end

  assign rdData = {rdLatch, {PAD_W{1'b0}}};
  assign nmiN   = !(vblFlag && nmiEnable);
endmodule

// File: rtl/vidStatusFlags.sv
module vidStatusFlags
  import vidStatusPkg::*;
#(
  parameter int LINE_W      = 9,
  parameter int DOT_W       = 9,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int VBL_LINE    = 241,
  parameter int PRE_LINE    = 261,
  parameter int SET_DOT     = 1,
  parameter int STATUS_ADDR = 2,
  parameter int HIT_DELAY   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pclk0En,
  input  logic              pclk1En,
  input  logic [LINE_W-1:0] lineNum,
  input  logic [DOT_W-1:0]  dotNum,
  input  logic              m2,
  input  logic              regSel,
  input  logic              cpuRw,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              spr0HitEv,
  input  logic              sprOvfEv,
  input  logic              nmiEnable,
  output logic [DATA_W-1:0] rdData,
  output logic              nmiN
);
  ctrlStrobeT strb;

  statusCtrl #(
    .LINE_W(LINE_W), .DOT_W(DOT_W), .ADDR_W(ADDR_W),
    .VBL_LINE(VBL_LINE), .PRE_LINE(PRE_LINE), .SET_DOT(SET_DOT),
    .STATUS_ADDR(STATUS_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pclk0En(pclk0En), .pclk1En(pclk1En),
    .lineNum(lineNum), .dotNum(dotNum), .m2(m2), .regSel(regSel),
    .cpuRw(cpuRw), .cpuAddr(cpuAddr), .sprOvfEv(sprOvfEv), .strb(strb)
  );

  statusData #(
    .DATA_W(DATA_W), .HIT_DELAY(HIT_DELAY)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .spr0HitEv(spr0HitEv),
    .nmiEnable(nmiEnable), .rdData(rdData), .nmiN(nmiN)
  );
endmodule

// File: rtl/vidStatusFlagsChk.sv
module vidStatusFlagsChk #(
  parameter int LINE_W      = 9,
  parameter int DOT_W       = 9,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int VBL_LINE    = 241,
  parameter int PRE_LINE    = 261,
  parameter int SET_DOT     = 1,
  parameter int STATUS_ADDR = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              pclk0En,
  input logic [LINE_W-1:0] lineNum,
  input logic [DOT_W-1:0]  dotNum,
  input logic              m2,
  input logic              regSel,
  input logic              cpuRw,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              nmiEnable,
  input logic [DATA_W-1:0] rdData,
  input logic              nmiN
);
  logic m2q;
  logic rdq;
  logic readAct;
  logic latchC;
  logic setC;
  logic preC;

  assign readAct = m2 && regSel && cpuRw && (cpuAddr == ADDR_W'(STATUS_ADDR));
  assign latchC  = readAct && !m2q;
  assign setC    = pclk0En && (lineNum == LINE_W'(VBL_LINE)) && (dotNum == DOT_W'(SET_DOT));
  assign preC    = pclk0En && (lineNum == LINE_W'(PRE_LINE)) && (dotNum == DOT_W'(SET_DOT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      m2q <= 1'b0;
      rdq <= 1'b0;
    end else begin
      m2q <= m2;
      if (latchC)   rdq <= 1'b1;
      else if (!m2) rdq <= 1'b0;
    end
  end

  AST_SET_RAISES_NMI: assert property (@(posedge clk) disable iff (!rstN)
    setC && !readAct |=> (nmiN == !nmiEnable)); // R1

  AST_RACE_DROPS_SET: assert property (@(posedge clk) disable iff (!rstN)
    setC && readAct && nmiN && nmiEnable |=> nmiN); // R6

  AST_PRE_RENDER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    preC |=> nmiN); // R11

  AST_READ_END_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    rdq && !m2 && !setC |=> nmiN); // R5

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(latchC) |-> $stable(rdData)); // R4
endmodule

bind vidStatusFlags vidStatusFlagsChk #(
  .LINE_W(LINE_W), .DOT_W(DOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .VBL_LINE(VBL_LINE), .PRE_LINE(PRE_LINE), .SET_DOT(SET_DOT),
  .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .pclk0En(pclk0En), .lineNum(lineNum),
  .dotNum(dotNum), .m2(m2), .regSel(regSel), .cpuRw(cpuRw),
  .cpuAddr(cpuAddr), .nmiEnable(nmiEnable), .rdData(rdData), .nmiN(nmiN)
);

// File: tb/vidStatusFlags_bench.sv
module vidStatusFlags_bench;
  localparam int SET_CYC = 10;
  localparam int RD_LEN  = 3;

  logic       clk = 1'b0;
  logic       rstN;
  logic       pclk0En, pclk1En;
  logic [8:0] lineNum, dotNum;
  logic       m2, regSel, cpuRw;
  logic [2:0] cpuAddr;
  logic       spr0HitEv, sprOvfEv, nmiEnable;
  logic [7:0] rdData;
  logic       nmiN;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vidStatusFlags u_vidStatusFlags (
    .clk(clk), .rstN(rstN), .pclk0En(pclk0En), .pclk1En(pclk1En),
    .lineNum(lineNum), .dotNum(dotNum), .m2(m2), .regSel(regSel),
    .cpuRw(cpuRw), .cpuAddr(cpuAddr), .spr0HitEv(spr0HitEv),
    .sprOvfEv(sprOvfEv), .nmiEnable(nmiEnable), .rdData(rdData), .nmiN(nmiN)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    pclk0En = 0; pclk1En = 0; lineNum = 0; dotNum = 0;
    m2 = 0; regSel = 0; cpuRw = 1; cpuAddr = 0;
    spr0HitEv = 0; sprOvfEv = 0;
  endtask

  task automatic doRead(logic sel, logic rw, logic [2:0] addr);
    regSel = sel; cpuRw = rw; cpuAddr = addr; m2 = 1;
    step();
    m2 = 0;
    step();
    regSel = 0; cpuRw = 1; cpuAddr = 0;
  endtask

  task automatic preClear();
    pclk0En = 1; lineNum = 9'd261; dotNum = 9'd1;
    step();
    idle();
  endtask

  task automatic setPoint();
    pclk0En = 1; lineNum = 9'd241; dotNum = 9'd1;
    step();
    idle();
  endtask

  task automatic pixTick(logic hit, logic ovf);
    pclk1En = 1; spr0HitEv = hit; sprOvfEv = ovf;
    step();
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; nmiEnable = 1; idle();
    repeat (3) step();
    chk("R12", "rdData in reset", rdData, 0);
    chk("R12", "nmiN in reset", nmiN, 1);
    rstN = 1;
    step();

    // R1: set point raises the flag, visible as NMI
    setPoint();
    chk("R1", "nmiN after set point", nmiN, 0);

    // R2: enable gates NMI
    nmiEnable = 0; step();
    chk("R2", "nmiN with enable off", nmiN, 1);
    nmiEnable = 1; step();
    chk("R2", "nmiN with enable back on", nmiN, 0);

    // R3: non-status accesses neither latch nor clear
    doRead(1, 1, 3'd3);
    chk("R3", "rdData after wrong address", rdData, 0);
    chk("R3", "nmiN after wrong address", nmiN, 0);
    doRead(1, 0, 3'd2);
    chk("R3", "rdData after write", rdData, 0);
    chk("R3", "nmiN after write", nmiN, 0);
    doRead(0, 1, 3'd2);
    chk("R3", "rdData with window off", rdData, 0);
    chk("R3", "nmiN with window off", nmiN, 0);

    // R4/R5: status read returns flag then clears it
    doRead(1, 1, 3'd2);
    chk("R4", "rdData from status read", rdData, 8'h80);
    chk("R5", "nmiN after status read", nmiN, 1);
    doRead(1, 1, 3'd2);
    chk("R4", "rdData from second read", rdData, 8'h00);

    // R9: hit flag appears at the second following pixel edge
    preClear();
    pixTick(1, 0);
    doRead(1, 1, 3'd2);
    chk("R9", "hit bit before delay", rdData[6], 0);
    pixTick(0, 0);
    doRead(1, 1, 3'd2);
    chk("R9", "hit bit after one edge", rdData[6], 0);
    pixTick(0, 0);
    doRead(1, 1, 3'd2);
    chk("R9", "hit bit after two edges", rdData[6], 1);

    // R10: overflow sets at once; reads leave hit and overflow
    pixTick(0, 1);
    doRead(1, 1, 3'd2);
    chk("R10", "status with hit and overflow", rdData, 8'h60);
    doRead(1, 1, 3'd2);
    chk("R10", "status after repeat read", rdData, 8'h60);

    // R11: pre-render clear of all flags
    setPoint();
    chk("R11", "nmiN before pre-render", nmiN, 0);
    preClear();
    chk("R11", "nmiN after pre-render", nmiN, 1);
    doRead(1, 1, 3'd2);
    chk("R11", "status after pre-render", rdData, 0);

    // R6/R7/R8: sweep read start across the set point
    for (int d = -6; d <= 6; d++) begin
      bit    seen;
      int    rdStart;
      int    expBit;
      int    expNmi;
      string req;
      preClear();
      seen    = 0;
      rdStart = SET_CYC + d;
      for (int c = 0; c < SET_CYC + 12; c++) begin
        regSel = 1; cpuRw = 1; cpuAddr = 3'd2;
        lineNum = 9'd241; dotNum = 9'd1;
        m2      = (c >= rdStart) && (c < rdStart + RD_LEN);
        pclk0En = (c == SET_CYC);
        step();
        if (!nmiN) seen = 1;
      end
      idle();
      step();
      expBit = (d > 0) ? 1 : 0;
      expNmi = ((d > 0) || (d <= -RD_LEN)) ? 1 : 0;
      if (d > 0)             req = "R8";
      else if (d <= -RD_LEN) req = "R7";
      else                   req = "R6";
      chk(req, $sformatf("read bit offset %0d", d), rdData[7], expBit);
      chk(req, $sformatf("nmi seen offset %0d", d), seen, expNmi);
      if (d > 0) chk("R8", $sformatf("nmiN released offset %0d", d), nmiN, 1);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule